// File: doc/BRIEF.md
# Multiply-Accumulate Saturation and Rounding Unit

This block is the arithmetic core of a multiply-accumulate engine. It forms a 32x32 product in one of three number formats (signed integer, unsigned integer, fractional), adds products into a file of four 64-bit accumulator slots that hold 48-bit values, saturates a slot in place, reads a slot out as a 32-bit or 16-bit result with optional convergent rounding and clamping, and derives condition flags from a slot. Each slot has a sticky overflow bit that stays set until software reloads or copies the slot.

A sequencer drives one operation per clock by raising `op_valid` with an operation code, a destination slot index, a source slot index and two operands. The mode register holds the format controls, the condition flags and the sticky bits. It is written with the mode-write operation and updated by the other operations, and its whole contents are visible on `mode_q`. Results appear on registered outputs one cycle after the strobe. The slot selected by `acc_idx` is always visible on `acc_view`.

Top module: `mac_sat_unit`

## Requirements
- R1: Signed-integer product (mode bit 0 clear, bit 1 set): when the 64-bit product is outside the 40-bit signed range, V (mode bit 7) is set. With saturate (bit 4) on, the product becomes 2^50, or the bitwise complement of 2^50 when the product is negative. With saturate off, it becomes the sign extension of its low 40 bits.
- R2: Unsigned product (bits 0 and 1 clear): any set product bit at position 40 or above sets V. The product then becomes 2^50 with saturate on, or its low 40 bits with saturate off.
- R3: Fractional product (bit 0 set): the signed product is shifted arithmetically right by 24. With round (bit 3) on, a discarded part above 0x800000 rounds up, and exactly 0x800000 rounds to the even neighbour.
- R4: Saturating a slot in signed-integer mode: a value outside the 48-bit signed range sets V and the slot's sticky bit (mode bit 9+slot). With saturate on, the slot is clamped to 0x7FFFFFFF or to its complement, following the sign. With saturate off, the slot becomes the sign extension of its low 48 bits.
- R5: Saturating a slot in fractional mode works as in R4, except that the clamp values are 0x7FFF_FFFF_FFFF and its complement.
- R6: Saturating a slot in unsigned mode: any set bit from 63 to 48 sets V and the sticky bit. With saturate on, a value above 2^53 becomes 0 and any other overflowing value becomes 2^48-1. With saturate off, the slot is truncated to 48 bits.
- R7: Fractional readout with the half-width control (bit 2) set: the value is shifted right by 24 and rounded to nearest even. Sixteen bits are kept and sign-extended. With saturate on, an out-of-range result becomes 0x7FFF or 0xFFFF8000, following the sign of the slot.
- R8: Fractional 32-bit readout shifts right by 8, rounding to even when round is on, and clamps to the signed 32-bit extremes when saturate is on. Signed-integer readout always clamps to the signed 32-bit range. Unsigned readout gives 0xFFFFFFFF when bits 63..32 are nonzero.
- R9: The flag operation writes Z (bit 6) for a zero slot, and otherwise writes N (bit 5) from slot bit 47. It ORs the slot's sticky bit into V. It writes EV (bit 8) when bits 63..40 (fractional) or 63..32 (signed) are not all equal, or, in unsigned mode, when bits 63..32 are nonzero.
- R10: A copy operation moves the source slot's value and sticky bit into the destination slot.
- R11: Operation codes are 0 mode write (mode register takes opa[12:0]), 1 multiply, 2 multiply-accumulate, 3 saturate, 4 readout, 5 flags, 6 copy, and 7 load (slot takes {opb,opa}, sticky cleared). Reset clears every register. A cycle with op_valid low changes no output or slot.
- R12: Multiply-accumulate adds the R1/R2/R3 product to the destination slot modulo 2^64, presents the product on prod_q, and sets V on product overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation strobe |
| op_sel | input | 3 | Operation code |
| acc_idx | input | 2 | Destination / selected slot |
| src_idx | input | 2 | Source slot for copy |
| opa | input | 32 | First operand, low load word, mode value |
| opb | input | 32 | Second operand, high load word |
| prod_q | output | 64 | Last product |
| rd_q | output | 32 | Last readout result |
| mode_q | output | 13 | Mode register: controls, flags, sticky bits |
| acc_view | output | 64 | Contents of the slot selected by acc_idx |

## Verification
Every cycle, the embedded assertions check several invariants. An unsigned product without saturation never carries bits above 39, and a saturated signed product is one of the two overflow markers. A slot saturated in signed or unsigned mode always lands inside its 48-bit range. A half-width readout is always a proper sign extension, N and Z are never both set, and a copy carries the source sticky bit. The exact rounding decisions need the bench's reference model: tie-to-even against round-up, the clamp values chosen by sign, the 2^53 threshold, and the EV boundaries in each format. The bench compares every output against that model on every clock, over directed corner values and a long random mix.

// File: rtl/mac_pkg.sv
package mac_pkg;
   typedef enum logic [2:0] {
      OP_MODE = 3'd0,
      OP_MUL  = 3'd1,
      OP_MAC  = 3'd2,
      OP_SAT  = 3'd3,
      OP_READ = 3'd4,
      OP_FLAG = 3'd5,
      OP_MOVE = 3'd6,
      OP_LOAD = 3'd7
   } mac_op_e;

   // mode register bit positions
   localparam int M_FRAC = 0;
   localparam int M_SGN  = 1;
   localparam int M_HALF = 2;
   localparam int M_RND  = 3;
   localparam int M_SAT  = 4;
   localparam int M_N    = 5;
   localparam int M_Z    = 6;
   localparam int M_V    = 7;
   localparam int M_EV   = 8;
   localparam int M_STK  = 9;
endpackage

// File: rtl/mac_round.sv
module mac_round #(
   parameter int W = 64,
   parameter int K = 8
) (
   input  logic [W-1:0] v,
   input  logic         en,
   output logic [W-1:0] q
);
   localparam logic [W-1:0] HALF = W'(1) << (K - 1);
   localparam logic [W-1:0] MASK = (W'(1) << K) - W'(1);

   logic [W-1:0] kept;
   logic [W-1:0] rem;

   assign kept = W'($signed(v) >>> K);
   assign rem  = v & MASK;

   always_comb begin
      q = kept;
      if (en) begin
         if (rem > HALF)       q = kept + W'(1);
         else if (rem == HALF) q = kept + W'(kept[0]);
      end
   end
endmodule

// File: rtl/mac_product.sv
module mac_product #(
   parameter int DATA_W     = 32,
   parameter int PROD_W     = 40,
   parameter int FRAC_SHIFT = 24,
   parameter int SAT_BIT    = 50
) (
   input  logic [DATA_W-1:0]   a,
   input  logic [DATA_W-1:0]   b,
   input  logic                frac,
   input  logic                sgn,
   input  logic                rnd,
   input  logic                sat,
   output logic [2*DATA_W-1:0] prod,
   output logic                ovf
);
   localparam int STORE_W = 2 * DATA_W;
   localparam logic [STORE_W-1:0] MARK = STORE_W'(1) << SAT_BIT;

   logic signed [STORE_W-1:0] sa, sb, sp;
   logic [STORE_W-1:0]        up, fr;
   logic [STORE_W-PROD_W:0]   s_hi;
   logic                      s_fit, u_ovf;

   assign sa = {{DATA_W{a[DATA_W-1]}}, a};
   assign sb = {{DATA_W{b[DATA_W-1]}}, b};
   assign sp = sa * sb;
   assign up = {{DATA_W{1'b0}}, a} * {{DATA_W{1'b0}}, b};

   mac_round #(.W(STORE_W), .K(FRAC_SHIFT)) frac_rnd_i (.v(sp), .en(rnd), .q(fr));

   assign s_hi  = sp[STORE_W-1:PROD_W-1];
   assign s_fit = (&s_hi) | ~(|s_hi);
   assign u_ovf = |up[STORE_W-1:PROD_W];

   always_comb begin
      ovf  = 1'b0;
      prod = fr;
      if (!frac) begin
         if (sgn) begin
            ovf  = ~s_fit;
            prod = sp;
            if (!s_fit) begin
               if (sat) prod = sp[STORE_W-1] ? ~MARK : MARK;
               else     prod = {{(STORE_W-PROD_W){sp[PROD_W-1]}}, sp[PROD_W-1:0]};
            end
         end else begin
            ovf  = u_ovf;
            prod = up;
            if (u_ovf) prod = sat ? MARK : {{(STORE_W-PROD_W){1'b0}}, up[PROD_W-1:0]};
         end
      end
   end
endmodule

// File: rtl/mac_saturate.sv
module mac_saturate #(
   parameter int DATA_W = 32,
   parameter int ACC_W  = 48
) (
   input  logic [2*DATA_W-1:0] v,
   input  logic                frac,
   input  logic                sgn,
   input  logic                sat,
   output logic [2*DATA_W-1:0] res,
   output logic                ovf
);
   localparam int STORE_W = 2 * DATA_W;
   localparam logic [STORE_W-1:0] SINT_MAX = STORE_W'({1'b0, {(DATA_W-1){1'b1}}});
   localparam logic [STORE_W-1:0] FRAC_MAX = (STORE_W'(1) << (ACC_W - 1)) - STORE_W'(1);
   localparam logic [STORE_W-1:0] UNS_MAX  = (STORE_W'(1) << ACC_W) - STORE_W'(1);
   localparam logic [STORE_W-1:0] UNS_THR  = STORE_W'(1) << (ACC_W + 5);

   logic [STORE_W-ACC_W:0] s_hi;
   logic s_fit, u_ovf;

   assign s_hi  = v[STORE_W-1:ACC_W-1];
   assign s_fit = (&s_hi) | ~(|s_hi);
   assign u_ovf = |v[STORE_W-1:ACC_W];

   always_comb begin
      res = v;
      if (frac || sgn) begin
         ovf = ~s_fit;
         if (!s_fit) begin
            if (!sat)      res = {{(STORE_W-ACC_W){v[ACC_W-1]}}, v[ACC_W-1:0]};
            else if (frac) res = v[STORE_W-1] ? ~FRAC_MAX : FRAC_MAX;
            else           res = v[STORE_W-1] ? ~SINT_MAX : SINT_MAX;
         end
      end else begin
         ovf = u_ovf;
         if (u_ovf) begin
            if (sat) res = (v > UNS_THR) ? '0 : UNS_MAX;
            else     res = v & UNS_MAX;
         end
      end
   end
endmodule

// File: rtl/mac_readout.sv
module mac_readout #(
   parameter int DATA_W     = 32,
   parameter int ACC_W      = 48,
   parameter int PROD_W     = 40,
   parameter int FRAC_SHIFT = 24
) (
   input  logic [2*DATA_W-1:0] v,
   input  logic                frac,
   input  logic                sgn,
   input  logic                half,
   input  logic                rnd,
   input  logic                sat,
   output logic [DATA_W-1:0]   rd,
   output logic                flag_n,
   output logic                flag_z,
   output logic                flag_ev
);
   localparam int STORE_W    = 2 * DATA_W;
   localparam int HALF_W     = DATA_W / 2;
   localparam int FINE_SHIFT = PROD_W - DATA_W;
   localparam logic [DATA_W-1:0] HMAX = DATA_W'({1'b0, {(HALF_W-1){1'b1}}});
   localparam logic [DATA_W-1:0] WMAX = {1'b0, {(DATA_W-1){1'b1}}};

   logic [STORE_W-1:0] qh, qf;
   logic neg, h_fit, f_fit, i_fit, u_fit;

   mac_round #(.W(STORE_W), .K(FRAC_SHIFT)) half_rnd_i (.v(v), .en(1'b1), .q(qh));
   mac_round #(.W(STORE_W), .K(FINE_SHIFT)) word_rnd_i (.v(v), .en(rnd), .q(qf));

   assign neg   = v[STORE_W-1];
   assign h_fit = (&qh[STORE_W-1:HALF_W-1]) | ~(|qh[STORE_W-1:HALF_W-1]);
   assign f_fit = (&qf[STORE_W-1:DATA_W-1]) | ~(|qf[STORE_W-1:DATA_W-1]);
   assign i_fit = (&v[STORE_W-1:DATA_W-1])  | ~(|v[STORE_W-1:DATA_W-1]);
   assign u_fit = ~(|v[STORE_W-1:DATA_W]);

   always_comb begin
      if (frac && half)
         rd = (sat && !h_fit) ? (neg ? ~HMAX : HMAX)
                              : {{HALF_W{qh[HALF_W-1]}}, qh[HALF_W-1:0]};
      else if (frac)
         rd = (sat && !f_fit) ? (neg ? ~WMAX : WMAX) : qf[DATA_W-1:0];
      else if (sgn)
         rd = i_fit ? v[DATA_W-1:0] : (neg ? ~WMAX : WMAX);
      else
         rd = u_fit ? v[DATA_W-1:0] : '1;
   end

   assign flag_z = (v == '0);
   assign flag_n = ~flag_z & v[ACC_W-1];

   always_comb begin
      if (frac)
         flag_ev = ~((&v[STORE_W-1:PROD_W]) | ~(|v[STORE_W-1:PROD_W]));
      else if (sgn)
         flag_ev = ~((&v[STORE_W-1:DATA_W]) | ~(|v[STORE_W-1:DATA_W]));
      else
         flag_ev = |v[STORE_W-1:DATA_W];
   end
endmodule

// File: rtl/mac_sat_unit.sv
module mac_sat_unit #(
   parameter int DATA_W     = 32,
   parameter int N_ACC      = 4,
   parameter int ACC_W      = 48,
   parameter int PROD_W     = 40,
   parameter int FRAC_SHIFT = 24,
   localparam int STORE_W   = 2 * DATA_W,
   localparam int IDX_W     = $clog2(N_ACC),
   localparam int MODE_W    = mac_pkg::M_STK + N_ACC
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               op_valid,
   input  logic [2:0]         op_sel,
   input  logic [IDX_W-1:0]   acc_idx,
   input  logic [IDX_W-1:0]   src_idx,
   input  logic [DATA_W-1:0]  opa,
   input  logic [DATA_W-1:0]  opb,
   output logic [STORE_W-1:0] prod_q,
   output logic [DATA_W-1:0]  rd_q,
   output logic [MODE_W-1:0]  mode_q,
   output logic [STORE_W-1:0] acc_view
);
   import mac_pkg::*;

   localparam int SAT_BIT = ACC_W + 2;
   localparam int HALF_W  = DATA_W / 2;

   generate
      if (N_ACC < 2 || (N_ACC & (N_ACC - 1)) != 0) begin : g_bad_nacc
         $error("N_ACC must be a power of two, at least 2");
      end
      if (!(DATA_W < PROD_W && PROD_W < ACC_W && ACC_W + 6 < STORE_W)) begin : g_bad_widths
         $error("width ordering DATA_W < PROD_W < ACC_W < STORE_W-6 violated");
      end
      if (FRAC_SHIFT <= PROD_W - DATA_W || FRAC_SHIFT >= DATA_W) begin : g_bad_shift
         $error("FRAC_SHIFT out of range");
      end
      if (MODE_W > DATA_W) begin : g_bad_mode
         $error("mode register wider than operand");
      end
   endgenerate

   mac_op_e op;
   assign op = mac_op_e'(op_sel);

   logic [STORE_W-1:0] acc_q [N_ACC];
   logic [STORE_W-1:0] acc_cur, acc_src, acc_d, prod_c, sat_res;
   logic [DATA_W-1:0]  rd_c;
   logic [MODE_W-1:0]  mode_d;
   logic mul_ovf, sat_ovf, fl_n, fl_z, fl_ev, acc_we, stk_src;
   logic m_frac, m_sgn, m_half, m_rnd, m_sat;

   assign m_frac = mode_q[M_FRAC];
   assign m_sgn  = mode_q[M_SGN];
   assign m_half = mode_q[M_HALF];
   assign m_rnd  = mode_q[M_RND];
   assign m_sat  = mode_q[M_SAT];

   assign acc_cur  = acc_q[acc_idx];
   assign acc_src  = acc_q[src_idx];
   assign acc_view = acc_cur;
   assign stk_src  = mode_q[M_STK + int'(src_idx)];

   mac_product #(.DATA_W(DATA_W), .PROD_W(PROD_W), .FRAC_SHIFT(FRAC_SHIFT), .SAT_BIT(SAT_BIT))
   product_i (.a(opa), .b(opb), .frac(m_frac), .sgn(m_sgn), .rnd(m_rnd), .sat(m_sat),
              .prod(prod_c), .ovf(mul_ovf));

   mac_saturate #(.DATA_W(DATA_W), .ACC_W(ACC_W))
   saturate_i (.v(acc_cur), .frac(m_frac), .sgn(m_sgn), .sat(m_sat),
               .res(sat_res), .ovf(sat_ovf));

   mac_readout #(.DATA_W(DATA_W), .ACC_W(ACC_W), .PROD_W(PROD_W), .FRAC_SHIFT(FRAC_SHIFT))
   readout_i (.v(acc_cur), .frac(m_frac), .sgn(m_sgn), .half(m_half), .rnd(m_rnd),
              .sat(m_sat), .rd(rd_c), .flag_n(fl_n), .flag_z(fl_z), .flag_ev(fl_ev));

   always_comb begin
      acc_we = op_valid;
      acc_d  = acc_cur;
      case (op)
         OP_MAC:  acc_d = acc_cur + prod_c;
         OP_SAT:  acc_d = sat_res;
         OP_MOVE: acc_d = acc_src;
         OP_LOAD: acc_d = {opb, opa};
         default: acc_we = 1'b0;
      endcase
   end

   always_comb begin
      mode_d = mode_q;
      if (op_valid) begin
         case (op)
            OP_MODE: mode_d = opa[MODE_W-1:0];
            OP_MUL, OP_MAC: if (mul_ovf) mode_d[M_V] = 1'b1;
            OP_SAT: if (sat_ovf) begin
               mode_d[M_V] = 1'b1;
               mode_d[M_STK + int'(acc_idx)] = 1'b1;
            end
            OP_FLAG: begin
               mode_d[M_N]  = fl_n;
               mode_d[M_Z]  = fl_z;
               mode_d[M_EV] = fl_ev;
               mode_d[M_V]  = mode_q[M_V] | mode_q[M_STK + int'(acc_idx)];
            end
            OP_MOVE: mode_d[M_STK + int'(acc_idx)] = stk_src;
            OP_LOAD: mode_d[M_STK + int'(acc_idx)] = 1'b0;
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < N_ACC; i++) acc_q[i] <= '0;
         mode_q <= '0;
         prod_q <= '0;
         rd_q   <= '0;
      end else begin
         mode_q <= mode_d;
         if (acc_we) acc_q[acc_idx] <= acc_d;
         if (op_valid && (op == OP_MUL || op == OP_MAC)) prod_q <= prod_c;
         if (op_valid && op == OP_READ) rd_q <= rd_c;
      end
   end

   // ---------------- assertions ----------------
   assert_uns_trunc_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op == OP_MUL && !m_frac && !m_sgn && !m_sat)
      |=> (prod_q[STORE_W-1:PROD_W] == '0));

   assert_sint_marker_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op == OP_MUL && !m_frac && m_sgn && m_sat && mul_ovf)
      |=> ((prod_q == (STORE_W'(1) << SAT_BIT)) || (prod_q == ~(STORE_W'(1) << SAT_BIT))) && mode_q[M_V]);

   assert_half_sext_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op == OP_READ && m_frac && m_half)
      |=> ((&rd_q[DATA_W-1:HALF_W-1]) || !(|rd_q[DATA_W-1:HALF_W-1])));

   assert_flag_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op == OP_FLAG) |=> !(mode_q[M_N] && mode_q[M_Z]));

   generate
      for (genvar g = 0; g < N_ACC; g++) begin : g_slot_chk
         assert_sint_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (op_valid && op == OP_SAT && acc_idx == IDX_W'(g) && !m_frac && m_sgn)
            |=> ((&acc_q[g][STORE_W-1:ACC_W-1]) || !(|acc_q[g][STORE_W-1:ACC_W-1])));

         assert_uns_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (op_valid && op == OP_SAT && acc_idx == IDX_W'(g) && !m_frac && !m_sgn)
            |=> (acc_q[g][STORE_W-1:ACC_W] == '0));

         assert_copy_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (op_valid && op == OP_MOVE && acc_idx == IDX_W'(g))
            |=> (mode_q[M_STK + g] == $past(stk_src)));
      end
   endgenerate
endmodule

// File: tb/mac_sat_unit_tb.sv
`timescale 1ns/1ps
module mac_sat_unit_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_valid = 1'b0;
   logic [2:0]  op_sel = '0;
   logic [1:0]  acc_idx = '0;
   logic [1:0]  src_idx = '0;
   logic [31:0] opa = '0;
   logic [31:0] opb = '0;
   logic [63:0] prod_q;
   logic [31:0] rd_q;
   logic [12:0] mode_q;
   logic [63:0] acc_view;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   // reference state
   logic [63:0] r_acc [4];
   logic [12:0] r_mode;
   logic [63:0] r_prod;
   logic [31:0] r_rd;

   always #2 clk = ~clk;

   mac_sat_unit dut_i (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel),
      .acc_idx(acc_idx), .src_idx(src_idx), .opa(opa), .opb(opb),
      .prod_q(prod_q), .rd_q(rd_q), .mode_q(mode_q), .acc_view(acc_view));

   function automatic longint shr_round(longint v, int k, bit en);
      longint q, rem, hf;
      q   = v >>> k;
      rem = v & ((64'sd1 <<< k) - 1);
      hf  = 64'sd1 <<< (k - 1);
      if (en) begin
         if (rem > hf) q = q + 1;
         else if (rem == hf) q = q + (q & 1);
      end
      return q;
   endfunction

   function automatic string tag_of(logic [2:0] op, logic [12:0] m, bit v);
      if (!v) return "R11";
      case (op)
         3'd1: return m[0] ? "R3" : (m[1] ? "R1" : "R2");
         3'd2: return "R12";
         3'd3: return m[0] ? "R5" : (m[1] ? "R4" : "R6");
         3'd4: return (m[0] && m[2]) ? "R7" : "R8";
         3'd5: return "R9";
         3'd6: return "R10";
         default: return "R11";
      endcase
   endfunction

   // behavioural product
   task automatic ref_product(input logic [31:0] a, input logic [31:0] b,
                              output logic [63:0] p, output bit ovf);
      longint sp;
      logic [63:0] up;
      sp  = longint'($signed(a)) * longint'($signed(b));
      up  = {32'd0, a} * {32'd0, b};
      ovf = 1'b0;
      if (r_mode[0]) begin
         p = shr_round(sp, 24, r_mode[3]);
      end else if (r_mode[1]) begin
         p = sp;
         if (sp > 64'sd549755813887 || sp < -64'sd549755813888) begin
            ovf = 1'b1;
            if (r_mode[4]) p = (sp < 0) ? ~(64'd1 << 50) : (64'd1 << 50);
            else           p = (sp <<< 24) >>> 24;
         end
      end else begin
         p = up;
         if (up >= (64'd1 << 40)) begin
            ovf = 1'b1;
            p = r_mode[4] ? (64'd1 << 50) : (up & ((64'd1 << 40) - 1));
         end
      end
   endtask

   task automatic ref_step(input logic [2:0] op, input int i, input int s,
                           input logic [31:0] a, input logic [31:0] b);
      logic [63:0] p, v;
      longint vs, q;
      bit ovf;
      v  = r_acc[i];
      vs = v;
      case (op)
         3'd0: r_mode = a[12:0];
         3'd1, 3'd2: begin
            ref_product(a, b, p, ovf);
            r_prod = p;
            if (ovf) r_mode[7] = 1'b1;
            if (op == 3'd2) r_acc[i] = v + p;
         end
         3'd3: begin
            if (r_mode[0] || r_mode[1]) begin
               if (vs > 64'sd140737488355327 || vs < -64'sd140737488355328) begin
                  r_mode[7] = 1'b1; r_mode[9+i] = 1'b1;
                  if (!r_mode[4])     r_acc[i] = (vs <<< 16) >>> 16;
                  else if (r_mode[0]) r_acc[i] = (vs < 0) ? -64'sd140737488355328 : 64'sd140737488355327;
                  else                r_acc[i] = (vs < 0) ? -64'sd2147483648 : 64'sd2147483647;
               end
            end else if (v >= (64'd1 << 48)) begin
               r_mode[7] = 1'b1; r_mode[9+i] = 1'b1;
               if (r_mode[4]) r_acc[i] = (v > (64'd1 << 53)) ? 64'd0 : ((64'd1 << 48) - 1);
               else           r_acc[i] = v & ((64'd1 << 48) - 1);
            end
         end
         3'd4: begin
            if (r_mode[0] && r_mode[2]) begin
               q = shr_round(vs, 24, 1'b1);
               if (r_mode[4] && (q > 32767 || q < -32768))
                  r_rd = (vs < 0) ? 32'hFFFF8000 : 32'h00007FFF;
               else
                  r_rd = {{16{q[15]}}, q[15:0]};
            end else if (r_mode[0]) begin
               q = shr_round(vs, 8, r_mode[3]);
               if (r_mode[4] && (q > 64'sd2147483647 || q < -64'sd2147483648))
                  r_rd = (vs < 0) ? 32'h80000000 : 32'h7FFFFFFF;
               else
                  r_rd = q[31:0];
            end else if (r_mode[1]) begin
               if (vs > 64'sd2147483647 || vs < -64'sd2147483648)
                  r_rd = (vs < 0) ? 32'h80000000 : 32'h7FFFFFFF;
               else
                  r_rd = v[31:0];
            end else begin
               r_rd = (v >= (64'd1 << 32)) ? 32'hFFFFFFFF : v[31:0];
            end
         end
         3'd5: begin
            r_mode[6] = (v == 0);
            r_mode[5] = (v != 0) && v[47];
            if (r_mode[9+i]) r_mode[7] = 1'b1;
            if (r_mode[0])      r_mode[8] = ((vs >>> 40) != 0) && ((vs >>> 40) != -1);
            else if (r_mode[1]) r_mode[8] = ((vs >>> 32) != 0) && ((vs >>> 32) != -1);
            else                r_mode[8] = (v >> 32) != 0;
         end
         3'd6: begin
            r_acc[i] = r_acc[s];
            r_mode[9+i] = r_mode[9+s];
         end
         default: begin
            r_acc[i] = {b, a};
            r_mode[9+i] = 1'b0;
         end
      endcase
   endtask

   task automatic check(input string tag, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   task automatic compare_all(input string tag);
      check(tag, "prod_q",   prod_q,   r_prod);
      check(tag, "rd_q",     {32'd0, rd_q}, {32'd0, r_rd});
      check(tag, "mode_q",   {51'd0, mode_q}, {51'd0, r_mode});
      check(tag, "acc_view", acc_view, r_acc[acc_idx]);
   endtask

   // one clock: drive at negedge, model at posedge, compare at next negedge
   task automatic cyc(input bit v, input logic [2:0] op, input int i, input int s,
                      input logic [31:0] a, input logic [31:0] b);
      string tag;
      tag      = tag_of(op, r_mode, v);
      op_valid = v;
      op_sel   = op;
      acc_idx  = 2'(i);
      src_idx  = 2'(s);
      opa      = a;
      opb      = b;
      @(posedge clk);
      if (v) ref_step(op, i, s, a, b);
      @(negedge clk);
      compare_all(tag);
   endtask

   task automatic set_mode(input logic [12:0] m);
      cyc(1'b1, 3'd0, 0, 0, {19'd0, m}, 32'd0);
   endtask

   task automatic load(input int i, input logic [63:0] val);
      cyc(1'b1, 3'd7, i, 0, val[31:0], val[63:32]);
   endtask

   // mode values: bit0 frac, bit1 signed, bit2 half, bit3 round, bit4 saturate
   localparam logic [12:0] MD_SINT  = 13'b0_0000_0000_0010;
   localparam logic [12:0] MD_SINTS = 13'b0_0000_0001_0010;
   localparam logic [12:0] MD_UNS   = 13'b0_0000_0000_0000;
   localparam logic [12:0] MD_UNSS  = 13'b0_0000_0001_0000;
   localparam logic [12:0] MD_FRACR = 13'b0_0000_0000_1001;
   localparam logic [12:0] MD_FRAC  = 13'b0_0000_0000_0001;
   localparam logic [12:0] MD_FRACS = 13'b0_0000_0001_1001;
   localparam logic [12:0] MD_FHS   = 13'b0_0000_0001_0101;

   initial begin
      for (int k = 0; k < 4; k++) r_acc[k] = '0;
      r_mode = '0; r_prod = '0; r_rd = '0;
      repeat (3) @(negedge clk);
      compare_all("R11");               // reset state
      rst_n = 1'b1;
      @(negedge clk);

      // R1 signed product
      set_mode(MD_SINT);
      cyc(1'b1, 3'd1, 0, 0, 32'd1000, 32'hFFFFFFFD);
      cyc(1'b1, 3'd1, 0, 0, 32'h7FFFFFFF, 32'h7FFFFFFF);
      set_mode(MD_SINTS);
      cyc(1'b1, 3'd1, 0, 0, 32'h80000000, 32'h7FFFFFFF);
      cyc(1'b1, 3'd1, 0, 0, 32'h7FFFFFFF, 32'h00001000);
      // R2 unsigned product
      set_mode(MD_UNS);
      cyc(1'b1, 3'd1, 0, 0, 32'hFFFFFFFF, 32'hFFFFFFFF);
      cyc(1'b1, 3'd1, 0, 0, 32'h000FFFFF, 32'h000FFFFF);
      set_mode(MD_UNSS);
      cyc(1'b1, 3'd1, 0, 0, 32'hFFFFFFFF, 32'h00000200);
      // R3 fractional rounding: tie to even down, tie to even up, above half
      set_mode(MD_FRACR);
      cyc(1'b1, 3'd1, 0, 0, 32'h00800000, 32'd1);
      cyc(1'b1, 3'd1, 0, 0, 32'h00800000, 32'd3);
      cyc(1'b1, 3'd1, 0, 0, 32'h00800001, 32'd1);
      cyc(1'b1, 3'd1, 0, 0, 32'hFF800000, 32'd1);
      set_mode(MD_FRAC);
      cyc(1'b1, 3'd1, 0, 0, 32'h00FFFFFF, 32'd1);
      // R12 accumulate
      set_mode(MD_SINT);
      load(1, 64'd5);
      cyc(1'b1, 3'd2, 1, 0, 32'd7, 32'hFFFFFFFF);
      cyc(1'b1, 3'd2, 1, 0, 32'd100, 32'd100);
      // R4 signed saturation
      load(2, 64'h0001_0000_0000_0000);
      cyc(1'b1, 3'd3, 2, 0, 32'd0, 32'd0);
      set_mode(MD_SINTS);
      load(2, 64'hFF00_0000_0000_0001);
      cyc(1'b1, 3'd3, 2, 0, 32'd0, 32'd0);
      load(3, 64'h0000_7FFF_FFFF_FFFF);
      cyc(1'b1, 3'd3, 3, 0, 32'd0, 32'd0);
      // R5 fractional saturation
      set_mode(MD_FRACS);
      load(0, 64'h0000_8000_0000_0000);
      cyc(1'b1, 3'd3, 0, 0, 32'd0, 32'd0);
      load(0, 64'h8000_0000_0000_0000);
      cyc(1'b1, 3'd3, 0, 0, 32'd0, 32'd0);
      // R6 unsigned saturation: above 2^53, exactly 2^53, truncate
      set_mode(MD_UNSS);
      load(1, 64'h0020_0000_0000_0001);
      cyc(1'b1, 3'd3, 1, 0, 32'd0, 32'd0);
      load(1, 64'h0020_0000_0000_0000);
      cyc(1'b1, 3'd3, 1, 0, 32'd0, 32'd0);
      set_mode(MD_UNS);
      load(1, 64'h1234_5678_9ABC_DEF0);
      cyc(1'b1, 3'd3, 1, 0, 32'd0, 32'd0);
      // R10 copy with sticky
      cyc(1'b1, 3'd6, 3, 1, 32'd0, 32'd0);
      cyc(1'b1, 3'd6, 1, 2, 32'd0, 32'd0);
      // R9 flags in each format
      cyc(1'b1, 3'd5, 3, 0, 32'd0, 32'd0);
      set_mode(MD_SINT);
      load(0, 64'd0);
      cyc(1'b1, 3'd5, 0, 0, 32'd0, 32'd0);
      load(0, 64'h0000_8000_0000_0000);
      cyc(1'b1, 3'd5, 0, 0, 32'd0, 32'd0);
      set_mode(MD_FRAC);
      load(0, 64'hFFFF_FF80_0000_0000);
      cyc(1'b1, 3'd5, 0, 0, 32'd0, 32'd0);
      // R7 half readout: tie, saturate both signs
      set_mode(MD_FHS);
      load(2, 64'h0000_0000_0280_0000);
      cyc(1'b1, 3'd4, 2, 0, 32'd0, 32'd0);
      load(2, 64'h0000_7000_0000_0000);
      cyc(1'b1, 3'd4, 2, 0, 32'd0, 32'd0);
      load(2, 64'hFFFF_9000_0000_0000);
      cyc(1'b1, 3'd4, 2, 0, 32'd0, 32'd0);
      // R8 word readouts
      set_mode(MD_FRACS);
      load(2, 64'h0000_0000_0000_0180);
      cyc(1'b1, 3'd4, 2, 0, 32'd0, 32'd0);
      load(2, 64'h0000_7000_0000_0000);
      cyc(1'b1, 3'd4, 2, 0, 32'd0, 32'd0);
      set_mode(MD_SINT);
      load(2, 64'hFFFF_FFF0_0000_0000);
      cyc(1'b1, 3'd4, 2, 0, 32'd0, 32'd0);
      set_mode(MD_UNS);
      cyc(1'b1, 3'd4, 2, 0, 32'd0, 32'd0);
      load(2, 64'd12345);
      cyc(1'b1, 3'd4, 2, 0, 32'd0, 32'd0);
      // R11 strobe low: nothing changes
      for (int k = 0; k < 8; k++) cyc(1'b0, 3'(k), k % 4, 0, 32'hDEADBEEF, 32'hCAFEF00D);

      // random mix
      for (int n = 0; n < 3000; n++) begin
         logic [2:0] op;
         logic [31:0] a, b;
         op = 3'($urandom % 8);
         a  = $urandom;
         b  = $urandom;
         if (op == 3'd0) a = {19'd0, 5'($urandom), 8'd0} | 32'($urandom % 32);
         if ($urandom % 3 == 0) begin a = a >> ($urandom % 32); b = b >> ($urandom % 32); end
         if (op == 3'd7 && $urandom % 2 == 0) b = {{16{b[15]}}, b[15:0]};
         cyc(($urandom % 8) != 0, op, int'($urandom % 4), int'($urandom % 4), a, b);
      end

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      #(4 * 150000);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL R11 watchdog: actual hung expected finished");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule